// File: doc/BRIEF.md
# Windowed-Carry Speculative Adder

This block adds two WIDTH-bit two's-complement operands and a carry input, but it never lets a carry travel further than a fixed window. Each result bit at position i is built only from the operand bits at positions i down to i−WIN+1, plus one carry that enters at the bottom of that window. Long carry runs are therefore cut off. The logic depth of the carry network follows the window length rather than the full width, and the price is an occasional wrong result when a real carry run is longer than the window.

Inside each window the group generate and propagate terms come from a parallel-prefix tree of doubling spans. The tree stops at the level that the window length needs. A compile-time mode selects the carry that is assumed at the bottom of each window. The first option is a constant zero, which can only underestimate the carry, so the errors are biased negative. The second option takes operand A's bit just below the window, which removes that bias on random data. An optional miss output is raised whenever the operands contain a carry run that the windows could have misjudged.

The adder is purely combinational. It is meant to be dropped into arithmetic datapaths that tolerate small error rates in exchange for a shallower carry network.

Top module: `apx_window_adder`

## Requirements
- R1: For every bit i ≥ WIN, sum bit i equals a_i XOR b_i XOR c, where c is the carry that comes from rippling through operand bits i−WIN+1 up to i−1, starting from that window's assumed carry-in. No other operand bit affects sum bit i.
- R2: With CIN_MODE = MODE_ZERO, the assumed window carry-in is 0. With b = ~a and carry_in = 1, the sum is all ones at positions WIN and above and zero below.
- R3: With CIN_MODE = MODE_ANTI, the assumed carry-in for the window of bit i is a_(i−WIN). With b = ~a and carry_in = 1, sum bit i equals NOT a_(i−WIN) for i ≥ WIN, and the bits below WIN are zero.
- R4: Sum bits at positions below min(WIN, WIDTH) always equal the exact sum bits of a + b + carry_in.
- R5: When WIN ≥ WIDTH, the sum always equals the exact (a + b + carry_in) mod 2^WIDTH, and the miss output stays 0.
- R6: When FLAG_EN = 1 and WIN < WIDTH, the miss output is 1 if and only if there is some i in [WIN, WIDTH−1] that meets the mode's condition. In MODE_ANTI, all propagate bits (a XOR b) at positions i−WIN up to i−1 are set. In MODE_ZERO, all propagate bits at positions i−WIN+1 up to i−1 are set and (a OR b) is 1 at position i−WIN. When FLAG_EN = 0, the miss output is 0.
- R7: Whenever the sum differs from the exact (a + b + carry_in) mod 2^WIDTH and FLAG_EN = 1, the miss output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0, always honoured by the low windows |
| sum_o | output | WIDTH | Windowed, possibly inexact sum |
| spec_miss_o | output | 1 | Raised when a carry run may have been misjudged |

## Verification
Five small configurations with a six-bit width are swept over every operand pair and both carry-in values. A window of 3 in each mode separates the two carry-in choices. A window equal to the width and a window wider than the width show that the adder falls back to exact addition, and the low bits must be exact in every configuration. At the default width, operands that are bitwise complements drive a propagate run across the whole word. For these, the expected sums follow directly from the mode, so they tell the zero-carry variant apart from the bias-cancelling one. A pseudo-random stream at the default width then compares the sum and the miss output against a bit-serial reference of the window rule and against true addition.

// File: rtl/apx_pkg.sv
package apx_pkg;

    typedef enum logic [0:0] {
        MODE_ZERO = 1'b0,
        MODE_ANTI = 1'b1
    } cin_mode_e;

    typedef struct packed {
        logic g;
        logic p;
    } pg_t;

    localparam pg_t PG_IDENT = '{g: 1'b0, p: 1'b1};

    function automatic int flog2(input int n);
        int r;
        r = 0;
        while ((2 ** (r + 1)) <= n) r++;
        return r;
    endfunction

    function automatic pg_t pg_merge(input pg_t hi, input pg_t lo);
        pg_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

endpackage

// File: rtl/apx_pg_gen.sv
module apx_pg_gen #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0]              a,
    input  logic [WIDTH-1:0]              b,
    output apx_pkg::pg_t [WIDTH-1:0]      pg
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign pg[i].g = a[i] & b[i];
        assign pg[i].p = a[i] ^ b[i];
    end
endmodule

// File: rtl/apx_ks_tree.sv
module apx_ks_tree #(
    parameter int WIDTH = 64,
    parameter int LEVELS = 4
) (
    input  apx_pkg::pg_t [WIDTH-1:0]              pg,
    output apx_pkg::pg_t [LEVELS:0][WIDTH-1:0]    node
);
    import apx_pkg::*;

    assign node[0] = pg;

    for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
        localparam int STEP = 2 ** (l - 1);
        for (genvar j = 0; j < WIDTH; j++) begin : g_pos
            if (j >= STEP) begin : g_merge
                assign node[l][j] = pg_merge(node[l-1][j], node[l-1][j-STEP]);
            end else begin : g_pass
                assign node[l][j] = node[l-1][j];
            end
        end
    end
endmodule

// File: rtl/apx_window_carry.sv
module apx_window_carry #(
    parameter int                 WIDTH    = 64,
    parameter int                 WIN      = 16,
    parameter int                 LEVELS   = 4,
    parameter apx_pkg::cin_mode_e CIN_MODE = apx_pkg::MODE_ANTI
) (
    input  logic [WIDTH-1:0]                      a,
    input  logic                                  carry_in,
    input  apx_pkg::pg_t [WIDTH-1:0]              pg,
    input  apx_pkg::pg_t [LEVELS:0][WIDTH-1:0]    node,
    output logic [WIDTH-1:0]                      carry,
    output logic [WIDTH-1:0]                      miss
);
    import apx_pkg::*;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        localparam int HI  = i - 1;
        localparam int LO  = (i < WIN) ? 0 : i - WIN + 1;
        localparam int LEN = HI - LO + 1;

        pg_t span;
        logic win_cin;

        if (LEN <= 0) begin : g_empty
            assign span = PG_IDENT;
        end else begin : g_span
            localparam int M = flog2(LEN);
            assign span = pg_merge(node[M][HI], node[M][LO + (2 ** M) - 1]);
        end

        if (i < WIN) begin : g_exact
            assign win_cin = carry_in;
            assign miss[i] = 1'b0;
        end else begin : g_spec
            if (CIN_MODE == MODE_ANTI) begin : g_anti
                localparam int FM = flog2(WIN);
                pg_t fspan;
                assign win_cin = a[i-WIN];
                assign fspan = pg_merge(node[FM][i-1], node[FM][i - WIN + (2 ** FM) - 1]);
                assign miss[i] = fspan.p;
            end else begin : g_zero
                assign win_cin = 1'b0;
                assign miss[i] = span.p & (pg[i-WIN].g | pg[i-WIN].p);
            end
        end

        assign carry[i] = span.g | (span.p & win_cin);
    end
endmodule

// File: rtl/apx_window_adder.sv
module apx_window_adder #(
    parameter int                 WIDTH    = 64,
    parameter int                 WIN      = 16,
    parameter apx_pkg::cin_mode_e CIN_MODE = apx_pkg::MODE_ANTI,
    parameter bit                 FLAG_EN  = 1'b1
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_o,
    output logic             spec_miss_o
);
    import apx_pkg::*;

    localparam int SPAN_MAX = (WIN < WIDTH - 1) ? WIN : WIDTH - 1;
    localparam int LEVELS   = flog2((SPAN_MAX < 1) ? 1 : SPAN_MAX);
    localparam int LOWN     = (WIN < WIDTH) ? WIN : WIDTH;

    pg_t [WIDTH-1:0]            pg;
    pg_t [LEVELS:0][WIDTH-1:0]  node;
    logic [WIDTH-1:0]           carry;
    logic [WIDTH-1:0]           miss;

    apx_pg_gen #(.WIDTH(WIDTH)) u_pg (
        .a (a_i),
        .b (b_i),
        .pg(pg)
    );

    apx_ks_tree #(.WIDTH(WIDTH), .LEVELS(LEVELS)) u_tree (
        .pg  (pg),
        .node(node)
    );

    apx_window_carry #(
        .WIDTH(WIDTH), .WIN(WIN), .LEVELS(LEVELS), .CIN_MODE(CIN_MODE)
    ) u_win (
        .a       (a_i),
        .carry_in(carry_in),
        .pg      (pg),
        .node    (node),
        .carry   (carry),
        .miss    (miss)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_sum
        assign sum_o[i] = pg[i].p ^ carry[i];
    end

    if (FLAG_EN) begin : g_flag
        assign spec_miss_o = |miss;
    end else begin : g_noflag
        assign spec_miss_o = 1'b0;
    end

    // Exact reference used only by the assertions below.
    logic [WIDTH:0]   exact_full;
    logic [WIDTH-1:0] exact_sum;
    logic [WIDTH-1:0] low_mask;
    always_comb begin
        exact_full = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_in};
        exact_sum  = exact_full[WIDTH-1:0];
        low_mask   = '0;
        for (int k = 0; k < LOWN; k++) low_mask[k] = 1'b1;
    end

    always_comb begin
        p_low_exact_r4: assert ((sum_o & low_mask) == (exact_sum & low_mask))
            else $error("R4 low bits differ from exact sum");
        if (WIN >= WIDTH) begin
            p_wide_exact_r5: assert (sum_o == exact_sum)
                else $error("R5 wide window not exact");
            p_wide_quiet_r5: assert (!spec_miss_o)
                else $error("R5 miss raised with wide window");
        end
        if (FLAG_EN) begin
            p_flag_covers_r7: assert ((sum_o == exact_sum) || spec_miss_o)
                else $error("R7 wrong sum without miss flag");
        end
    end
endmodule

// File: tb/apx_window_adder_test.sv
module apx_window_adder_test;
    import apx_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // default-size instances
    logic [63:0] a64 = '0, b64 = '0;
    logic        c64 = 1'b0;
    logic [63:0] s_anti64, s_zero64;
    logic        m_anti64, m_zero64;

    apx_window_adder uut (
        .a_i(a64), .b_i(b64), .carry_in(c64), .sum_o(s_anti64), .spec_miss_o(m_anti64)
    );
    apx_window_adder #(.WIDTH(64), .WIN(16), .CIN_MODE(MODE_ZERO)) u_z64 (
        .a_i(a64), .b_i(b64), .carry_in(c64), .sum_o(s_zero64), .spec_miss_o(m_zero64)
    );

    // small instances
    logic [5:0] a6 = '0, b6 = '0;
    logic       c6 = 1'b0;
    logic [5:0] s_z3, s_a3, s_e6, s_e9, s_nf;
    logic       m_z3, m_a3, m_e6, m_e9, m_nf;

    apx_window_adder #(.WIDTH(6), .WIN(3), .CIN_MODE(MODE_ZERO)) u_z3 (
        .a_i(a6), .b_i(b6), .carry_in(c6), .sum_o(s_z3), .spec_miss_o(m_z3));
    apx_window_adder #(.WIDTH(6), .WIN(3), .CIN_MODE(MODE_ANTI)) u_a3 (
        .a_i(a6), .b_i(b6), .carry_in(c6), .sum_o(s_a3), .spec_miss_o(m_a3));
    apx_window_adder #(.WIDTH(6), .WIN(6), .CIN_MODE(MODE_ZERO)) u_e6 (
        .a_i(a6), .b_i(b6), .carry_in(c6), .sum_o(s_e6), .spec_miss_o(m_e6));
    apx_window_adder #(.WIDTH(6), .WIN(9), .CIN_MODE(MODE_ANTI)) u_e9 (
        .a_i(a6), .b_i(b6), .carry_in(c6), .sum_o(s_e9), .spec_miss_o(m_e9));
    apx_window_adder #(.WIDTH(6), .WIN(2), .CIN_MODE(MODE_ANTI), .FLAG_EN(1'b0)) u_nf (
        .a_i(a6), .b_i(b6), .carry_in(c6), .sum_o(s_nf), .spec_miss_o(m_nf));

    function automatic logic [63:0] wmask(input int w);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < w; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [63:0] exact_add(input logic [63:0] a, input logic [63:0] b,
                                              input logic ci, input int w);
        return (a + b + {63'd0, ci}) & wmask(w);
    endfunction

    function automatic logic [63:0] ref_sum(input logic [63:0] a, input logic [63:0] b,
                                            input logic ci, input int w, input int k,
                                            input bit anti);
        logic [63:0] s;
        s = '0;
        for (int i = 0; i < w; i++) begin
            logic c;
            int lo;
            if (i < k) begin
                lo = 0;
                c  = ci;
            end else begin
                lo = i - k + 1;
                c  = anti ? a[i-k] : 1'b0;
            end
            for (int j = lo; j < i; j++) c = (a[j] & b[j]) | ((a[j] ^ b[j]) & c);
            s[i] = a[i] ^ b[i] ^ c;
        end
        return s;
    endfunction

    function automatic logic ref_miss(input logic [63:0] a, input logic [63:0] b,
                                      input int w, input int k, input bit anti);
        logic any;
        any = 1'b0;
        if (k < w) begin
            for (int i = k; i < w; i++) begin
                logic run;
                run = 1'b1;
                if (anti) begin
                    for (int j = i - k; j < i; j++) run &= a[j] ^ b[j];
                end else begin
                    for (int j = i - k + 1; j < i; j++) run &= a[j] ^ b[j];
                    run &= a[i-k] | b[i-k];
                end
                any |= run;
            end
        end
        return any;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (a=%h b=%h)", req, act, exp,
                     (a64 | {58'd0, a6}), (b64 | {58'd0, b6}));
        end
    endtask

    task automatic small_cfg(input logic [5:0] s, input logic m, input int k, input bit anti,
                             input bit flag_en, input string tag);
        logic [63:0] ex, rs;
        logic        rm;
        ex = exact_add({58'd0, a6}, {58'd0, b6}, c6, 6);
        rs = ref_sum({58'd0, a6}, {58'd0, b6}, c6, 6, k, anti);
        rm = flag_en ? ref_miss({58'd0, a6}, {58'd0, b6}, 6, k, anti) : 1'b0;
        chk({58'd0, s} == rs, {"R1 window sum ", tag}, {58'd0, s}, rs);
        chk(m == rm, {"R6 miss flag ", tag}, {63'd0, m}, {63'd0, rm});
        chk(({58'd0, s} & wmask(k < 6 ? k : 6)) == (ex & wmask(k < 6 ? k : 6)),
            {"R4 low bits exact ", tag}, {58'd0, s}, ex);
        if (k >= 6) begin
            chk({58'd0, s} == ex, {"R5 wide exact ", tag}, {58'd0, s}, ex);
            chk(m == 1'b0, {"R5 wide quiet ", tag}, {63'd0, m}, 64'd0);
        end
        if (flag_en && ({58'd0, s} != ex))
            chk(m == 1'b1, {"R7 miss covers error ", tag}, {63'd0, m}, 64'd1);
    endtask

    task automatic big_check(input string tag);
        logic [63:0] ex, ra, rz;
        ex = exact_add(a64, b64, c64, 64);
        ra = ref_sum(a64, b64, c64, 64, 16, 1'b1);
        rz = ref_sum(a64, b64, c64, 64, 16, 1'b0);
        chk(s_anti64 == ra, {"R1 anti sum ", tag}, s_anti64, ra);
        chk(s_zero64 == rz, {"R1 zero sum ", tag}, s_zero64, rz);
        chk(m_anti64 == ref_miss(a64, b64, 64, 16, 1'b1), {"R6 anti miss ", tag},
            {63'd0, m_anti64}, {63'd0, ref_miss(a64, b64, 64, 16, 1'b1)});
        chk(m_zero64 == ref_miss(a64, b64, 64, 16, 1'b0), {"R6 zero miss ", tag},
            {63'd0, m_zero64}, {63'd0, ref_miss(a64, b64, 64, 16, 1'b0)});
        chk((s_anti64 & 64'hFFFF) == (ex & 64'hFFFF), {"R4 low exact ", tag}, s_anti64, ex);
        if (s_anti64 != ex) chk(m_anti64, {"R7 anti covers ", tag}, {63'd0, m_anti64}, 64'd1);
        if (s_zero64 != ex) chk(m_zero64, {"R7 zero covers ", tag}, {63'd0, m_zero64}, 64'd1);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] lfsr;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // idle state: zero operands give zero sum and no miss
        @(negedge clk);
        chk(s_anti64 == 64'd0 && !m_anti64, "R1 idle zero", s_anti64, 64'd0);
        chk(s_z3 == 6'd0 && !m_z3, "R6 idle zero small", {58'd0, s_z3}, 64'd0);

        // exhaustive sweep of the six-bit configurations
        for (int ci = 0; ci < 2; ci++) begin
            for (int ai = 0; ai < 64; ai++) begin
                for (int bi = 0; bi < 64; bi++) begin
                    @(posedge clk);
                    a6 = 6'(ai); b6 = 6'(bi); c6 = 1'(ci);
                    @(negedge clk);
                    small_cfg(s_z3, m_z3, 3, 1'b0, 1'b1, "w3 zero");
                    small_cfg(s_a3, m_a3, 3, 1'b1, 1'b1, "w3 anti");
                    small_cfg(s_e6, m_e6, 6, 1'b0, 1'b1, "w6");
                    small_cfg(s_e9, m_e9, 9, 1'b1, 1'b1, "w9");
                    small_cfg(s_nf, m_nf, 2, 1'b1, 1'b0, "w2 noflag");
                end
            end
        end
        a6 = '0; b6 = '0; c6 = 1'b0;

        // complementary operands: full-width propagate run
        for (int v = 0; v < 3; v++) begin
            @(posedge clk);
            a64 = (v == 0) ? 64'h0123_4567_89AB_CDEF :
                  (v == 1) ? 64'h8000_0000_0000_0000 : 64'hFFFF_0000_FFFF_0000;
            b64 = ~a64;
            c64 = 1'b1;
            @(negedge clk);
            chk(s_zero64 == ~64'hFFFF, "R2 zero-mode complement", s_zero64, ~64'hFFFF);
            chk(s_anti64 == ((~a64) << 16), "R3 anti-mode complement", s_anti64,
                (~a64) << 16);
            chk(m_zero64 && m_anti64, "R7 complement miss", {62'd0, m_zero64, m_anti64},
                64'd3);
        end

        // MSB failure: run of ones reaching bit 63 fed by a low generate
        @(posedge clk);
        a64 = 64'h7FFF_FFFF_FFFF_FFFF; b64 = 64'd1; c64 = 1'b0;
        @(negedge clk);
        big_check("msb run");

        // pseudo-random stream
        lfsr = 64'hACE1_2468_9BDF_1357;
        for (int n = 0; n < 3000; n++) begin
            @(posedge clk);
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            a64 = lfsr;
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            b64 = (n % 4 == 0) ? ~a64 ^ (64'd1 << (n % 64)) : lfsr;
            c64 = lfsr[7];
            @(negedge clk);
            big_check("random");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule